// File: doc/BRIEF.md
# Per-ID Ordering Hazard Stall Tracker

This block sits on the read-command or write-command path of a master-side bus bridge. It counts, for every transaction ID, how many responses are still due. For each ID it also keeps the target slave index and the QoS class of the most recent accepted command. When accepting a new command could let its responses come back out of order, the block holds that command back. It stalls the command by clearing ready toward the upstream master and valid toward the downstream side, so the command waits unchanged until the hazard goes away.

The stall rule depends on a mode input. With in-order delivery, three things stall a command: it targets a slave other than the one its ID is waiting on, it must be split while anything is outstanding, or it follows a split command whose segments have not all returned. With reordering enabled, a command stalls only when its QoS class differs from the class already outstanding on its ID. A response handshake retires one outstanding entry. Empty and full flags report the global occupancy, a stall flag reports a hazard, and a per-slave flag reports whether anything is outstanding to a queried slave index.

Top module: `ordering_hazard_tracker`

## Requirements
- R1: After reset `empty_o`=1, and `full_o`, `stall_o` and `slv_busy_o` are 0 for every queried slave.
- R2: With `reorder_en`=0, a command stalls when its ID has outstanding responses and the recorded slave index of that ID differs from `cmd_slv_i`. A command that targets the recorded slave, or whose ID has nothing outstanding, does not stall for this reason.
- R3: With `reorder_en`=0, a command with `cmd_segs_i` of 2 or more stalls while any command on any ID is outstanding.
- R4: With `reorder_en`=0, once a command with 2 or more segments has been accepted, every later command stalls until the global outstanding count returns to zero.
- R5: With `reorder_en`=1, a command stalls only when its ID has outstanding responses and the recorded QoS differs from `cmd_qos_i`. A slave change or a split never stalls in this mode.
- R6: `dn_valid_o` = `cmd_valid_i` and no hazard and enough room. `cmd_ready_o` = `dn_valid_o` and `dn_ready_i`. A command is accepted on a cycle where `cmd_valid_i` and `cmd_ready_o` are both 1.
- R7: An accepted command adds its segment count to its ID and to the global count, and a `cmd_segs_i` of 0 counts as 1. A response with `rsp_valid_i`=1 retires one entry of `rsp_id_i`. A response on an ID whose count is zero is ignored.
- R8: `full_o` is 1 exactly when the global count equals `MAX_OUT`. A command whose segments would push the count past `MAX_OUT` is not accepted.
- R9: `empty_o` is 1 exactly when the global count is zero.
- R10: `slv_busy_o` is 1 when at least one entry is outstanding to slave `query_slv_i`. Each response names its slave on `rsp_slv_i`.
- R11: When a single-segment command and a response for the same ID complete in the same cycle, the counts are left unchanged.
- R12: `stall_o` is 1 only for an ordering hazard on a valid command, never for a lack of room. It is 0 whenever `empty_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reorder_en | input | 1 | 1: responses may be reordered downstream |
| cmd_valid_i | input | 1 | Upstream command valid |
| cmd_ready_o | output | 1 | Upstream command ready |
| cmd_id_i | input | ID_W | Command transaction ID |
| cmd_slv_i | input | SLV_W | Decoded target slave index |
| cmd_qos_i | input | QOS_W | Command QoS class |
| cmd_segs_i | input | CNT_W | Number of segments (0 or 1: unsplit) |
| dn_valid_o | output | 1 | Downstream command valid |
| dn_ready_i | input | 1 | Downstream command ready |
| rsp_valid_i | input | 1 | Response retire strobe |
| rsp_id_i | input | ID_W | ID of the retiring response |
| rsp_slv_i | input | SLV_W | Slave that sent the response |
| query_slv_i | input | SLV_W | Slave index to report on |
| slv_busy_o | output | 1 | Entries outstanding to query_slv_i |
| stall_o | output | 1 | Valid command held on a hazard |
| empty_o | output | 1 | Nothing outstanding |
| full_o | output | 1 | MAX_OUT entries outstanding |

## Verification
The hardest state to reach is the split-drain window. In that window a split command has been accepted and other IDs with free slots are still locked out until the last segment retires. Ordinary traffic rarely crosses this with the right mix of IDs, slaves and segment counts. The bench plants a single seed command for every mode, seed ID, slave and segment count. With downstream ready held low, nothing is accepted, so it can then probe every combination of ID, slave, QoS and segment count combinationally, and it compares each result against a model of the stall rules. The full boundary and same-cycle accept-and-retire are built up by explicit sequences.

// File: rtl/oht_pkg.sv
// Shared types for the ordering hazard tracker.
package oht_pkg;
    // State of the global split-drain lock used in in-order mode.
    typedef enum logic {
        SPLIT_IDLE  = 1'b0,
        SPLIT_DRAIN = 1'b1
    } split_st_e;
endpackage

// File: rtl/oht_count.sv
// Up/down occupancy counter.
// Adds inc_val when inc_en is set and removes one when dec_en is set.
// Assumes the caller never adds past 2**W-1. A decrement at zero is dropped.
module oht_count #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_en,
    input  logic [W-1:0] inc_val,
    input  logic         dec_en,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] add_v;
    logic [W-1:0] sub_v;

    // Select the increment and guarded decrement amounts.
    always_comb begin
        add_v = inc_en ? inc_val : '0;
        sub_v = (dec_en && (cnt_o != '0)) ? W'(1) : '0;
    end

    // Register the new occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_o + add_v - sub_v;
    end
endmodule

// File: rtl/oht_id_slot.sv
// One per-ID tracking slot: outstanding count plus the slave index and QoS
// of the latest accepted command. Assumes load_i is only raised on accept.
module oht_id_slot #(
    parameter int CNT_W = 3,
    parameter int SLV_W = 2,
    parameter int QOS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] seg_i,
    input  logic [SLV_W-1:0] slv_i,
    input  logic [QOS_W-1:0] qos_i,
    input  logic             retire_i,
    output logic             busy_o,
    output logic [SLV_W-1:0] slv_o,
    output logic [QOS_W-1:0] qos_o
);
    logic [CNT_W-1:0] cnt;

    oht_count #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (load_i),
        .inc_val (seg_i),
        .dec_en  (retire_i),
        .cnt_o   (cnt)
    );

    assign busy_o = |cnt;

    // Capture the target tags of each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slv_o <= '0;
            qos_o <= '0;
        end else if (load_i) begin
            slv_o <= slv_i;
            qos_o <= qos_i;
        end
    end
endmodule

// File: rtl/oht_hazard.sv
// Combinational ordering-hazard decision for the presented command.
// Inputs are the selected ID slot, the global occupancy and the split lock.
module oht_hazard #(
    parameter int SLV_W = 2,
    parameter int QOS_W = 2
) (
    input  logic             reorder_en,
    input  logic             slot_busy,
    input  logic [SLV_W-1:0] slot_slv,
    input  logic [QOS_W-1:0] slot_qos,
    input  logic [SLV_W-1:0] cmd_slv,
    input  logic [QOS_W-1:0] cmd_qos,
    input  logic             cmd_split,
    input  logic             any_out,
    input  logic             split_lock,
    output logic             hazard_o
);
    logic slv_clash;
    logic qos_clash;
    logic split_block;

    // Evaluate each hazard cause and pick by mode.
    always_comb begin
        slv_clash   = slot_busy && (slot_slv != cmd_slv);
        qos_clash   = slot_busy && (slot_qos != cmd_qos);
        split_block = any_out && (cmd_split || split_lock);
        hazard_o    = reorder_en ? qos_clash : (slv_clash || split_block);
    end
endmodule

// File: rtl/ordering_hazard_tracker.sv
// Per-ID ordering hazard stall tracker for one command channel.
// Holds a command back (ready and downstream valid low) when accepting it
// could let responses return out of order. Assumes the master keeps a stalled
// command stable, each response names the slave it came from, and
// cmd_segs_i never exceeds MAX_OUT.
module ordering_hazard_tracker
    import oht_pkg::*;
#(
    parameter int ID_W    = 2,
    parameter int MAX_OUT = 6,
    parameter int SLV_W   = 2,
    parameter int QOS_W   = 2,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reorder_en,
    input  logic             cmd_valid_i,
    output logic             cmd_ready_o,
    input  logic [ID_W-1:0]  cmd_id_i,
    input  logic [SLV_W-1:0] cmd_slv_i,
    input  logic [QOS_W-1:0] cmd_qos_i,
    input  logic [CNT_W-1:0] cmd_segs_i,
    output logic             dn_valid_o,
    input  logic             dn_ready_i,
    input  logic             rsp_valid_i,
    input  logic [ID_W-1:0]  rsp_id_i,
    input  logic [SLV_W-1:0] rsp_slv_i,
    input  logic [SLV_W-1:0] query_slv_i,
    output logic             slv_busy_o,
    output logic             stall_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int NUM_ID  = 1 << ID_W;
    localparam int NUM_SLV = 1 << SLV_W;
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_OUT);
    localparam logic [CNT_W:0]   MAX_W = (CNT_W + 1)'(MAX_OUT);

    logic [NUM_ID-1:0]  id_busy;
    logic [SLV_W-1:0]   id_slv [NUM_ID];
    logic [QOS_W-1:0]   id_qos [NUM_ID];
    logic [NUM_SLV-1:0] slv_nz;
    logic [CNT_W-1:0]   total;
    logic [CNT_W-1:0]   eff_segs;
    logic [CNT_W:0]     after_add;
    logic               room_ok;
    logic               hazard;
    logic               accept;
    logic               retire_ok;
    logic               cmd_split;
    split_st_e          split_q;

    // Normalise the segment count and test for capacity.
    always_comb begin
        eff_segs  = (cmd_segs_i == '0) ? CNT_W'(1) : cmd_segs_i;
        cmd_split = eff_segs > CNT_W'(1);
        after_add = {1'b0, total} + {1'b0, eff_segs};
        room_ok   = after_add <= MAX_W;
    end

    oht_hazard #(.SLV_W(SLV_W), .QOS_W(QOS_W)) u_haz (
        .reorder_en (reorder_en),
        .slot_busy  (id_busy[cmd_id_i]),
        .slot_slv   (id_slv[cmd_id_i]),
        .slot_qos   (id_qos[cmd_id_i]),
        .cmd_slv    (cmd_slv_i),
        .cmd_qos    (cmd_qos_i),
        .cmd_split  (cmd_split),
        .any_out    (!empty_o),
        .split_lock (split_q == SPLIT_DRAIN),
        .hazard_o   (hazard)
    );

    // Gate the handshake in both directions.
    always_comb begin
        stall_o     = cmd_valid_i && hazard;
        dn_valid_o  = cmd_valid_i && !hazard && room_ok;
        cmd_ready_o = dn_valid_o && dn_ready_i;
        accept      = cmd_valid_i && cmd_ready_o;
        retire_ok   = rsp_valid_i && id_busy[rsp_id_i];
    end

    // One tracking slot per transaction ID.
    for (genvar g = 0; g < NUM_ID; g++) begin : g_slot
        oht_id_slot #(.CNT_W(CNT_W), .SLV_W(SLV_W), .QOS_W(QOS_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (accept && (cmd_id_i == ID_W'(g))),
            .seg_i    (eff_segs),
            .slv_i    (cmd_slv_i),
            .qos_i    (cmd_qos_i),
            .retire_i (rsp_valid_i && (rsp_id_i == ID_W'(g))),
            .busy_o   (id_busy[g]),
            .slv_o    (id_slv[g]),
            .qos_o    (id_qos[g])
        );
    end

    // One occupancy counter per slave index.
    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        logic [CNT_W-1:0] scnt;
        oht_count #(.W(CNT_W)) u_scnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_en  (accept && (cmd_slv_i == SLV_W'(s))),
            .inc_val (eff_segs),
            .dec_en  (retire_ok && (rsp_slv_i == SLV_W'(s))),
            .cnt_o   (scnt)
        );
        assign slv_nz[s] = |scnt;
    end

    oht_count #(.W(CNT_W)) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (accept),
        .inc_val (eff_segs),
        .dec_en  (retire_ok),
        .cnt_o   (total)
    );

    // Occupancy flags and per-slave report.
    always_comb begin
        empty_o    = (total == '0);
        full_o     = (total == MAX_C);
        slv_busy_o = slv_nz[query_slv_i];
    end

    // Split-drain lock: set by an in-order split, released once drained.
    always_ff @(posedge clk) begin
        if (!rst_n)
            split_q <= SPLIT_IDLE;
        else if (accept && cmd_split && !reorder_en)
            split_q <= SPLIT_DRAIN;
        else if (empty_o)
            split_q <= SPLIT_IDLE;
    end
endmodule

// File: rtl/oht_checker.sv
// Port-level temporal checks for ordering_hazard_tracker, bound below.
module oht_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid_i,
    input logic cmd_ready_o,
    input logic dn_valid_o,
    input logic dn_ready_i,
    input logic rsp_valid_i,
    input logic stall_o,
    input logic empty_o,
    input logic full_o
);
    p_fwd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid_o |-> (cmd_valid_i && !stall_o));

    p_ready_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> (dn_ready_i && dn_valid_o));

    p_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !cmd_ready_o);

    p_full_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(cmd_valid_i && cmd_ready_o));

    p_empty_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_o) |-> $past(rsp_valid_i));

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    p_no_stall_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !stall_o);
endmodule

bind ordering_hazard_tracker oht_checker u_oht_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .dn_valid_o  (dn_valid_o),
    .dn_ready_i  (dn_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .stall_o     (stall_o),
    .empty_o     (empty_o),
    .full_o      (full_o)
);

// File: tb/tb_ordering_hazard_tracker.sv
`timescale 1ns/1ps
module tb_ordering_hazard_tracker;
    localparam int MAX_OUT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reorder_en = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic       cmd_ready_o;
    logic [1:0] cmd_id_i = '0;
    logic [1:0] cmd_slv_i = '0;
    logic [1:0] cmd_qos_i = '0;
    logic [2:0] cmd_segs_i = '0;
    logic       dn_valid_o;
    logic       dn_ready_i = 1'b0;
    logic       rsp_valid_i = 1'b0;
    logic [1:0] rsp_id_i = '0;
    logic [1:0] rsp_slv_i = '0;
    logic [1:0] query_slv_i = '0;
    logic       slv_busy_o, stall_o, empty_o, full_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the tracker state.
    int m_cnt[4];
    int m_slv[4];
    int m_qos[4];
    int m_scnt[4];
    int m_total = 0;
    bit m_split = 0;

    always #2.5 clk = ~clk;

    ordering_hazard_tracker dut (
        .clk(clk), .rst_n(rst_n), .reorder_en(reorder_en),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_id_i(cmd_id_i), .cmd_slv_i(cmd_slv_i), .cmd_qos_i(cmd_qos_i),
        .cmd_segs_i(cmd_segs_i), .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready_i),
        .rsp_valid_i(rsp_valid_i), .rsp_id_i(rsp_id_i), .rsp_slv_i(rsp_slv_i),
        .query_slv_i(query_slv_i), .slv_busy_o(slv_busy_o), .stall_o(stall_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eseg(int s);
        return (s == 0) ? 1 : s;
    endfunction

    function automatic bit exp_haz(int id, int slv, int qos, int s);
        if (reorder_en) return (m_cnt[id] != 0) && (m_qos[id] != qos);
        return (m_total != 0 && (m_split || eseg(s) > 1)) ||
               (m_cnt[id] != 0 && m_slv[id] != slv);
    endfunction

    function automatic bit exp_room(int s);
        return (m_total + eseg(s)) <= MAX_OUT;
    endfunction

    function automatic void model_add(int id, int slv, int qos, int s);
        if (m_total == 0) m_split = 0;
        if (!reorder_en && eseg(s) > 1) m_split = 1;
        m_cnt[id] += eseg(s);
        m_total   += eseg(s);
        m_scnt[slv] += eseg(s);
        m_slv[id] = slv;
        m_qos[id] = qos;
    endfunction

    function automatic void model_ret(int id, int slv);
        if (m_cnt[id] > 0) begin
            m_cnt[id]--;
            m_total--;
            m_scnt[slv]--;
        end
    endfunction

    // Present a command, expect acceptance (R6), and commit it.
    task automatic commit(int id, int slv, int qos, int s);
        @(negedge clk);
        cmd_id_i = 2'(id); cmd_slv_i = 2'(slv); cmd_qos_i = 2'(qos);
        cmd_segs_i = 3'(s); cmd_valid_i = 1; dn_ready_i = 1;
        #1;
        chk("R6 accept", int'(cmd_ready_o), 1);
        @(posedge clk);
        model_add(id, slv, qos, s);
        #1;
        cmd_valid_i = 0; dn_ready_i = 0;
    endtask

    // Retire one response.
    task automatic retire(int id, int slv);
        @(negedge clk);
        rsp_id_i = 2'(id); rsp_slv_i = 2'(slv); rsp_valid_i = 1;
        @(posedge clk);
        model_ret(id, slv);
        #1;
        rsp_valid_i = 0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 empty", int'(empty_o), 1);
        chk("R1 full", int'(full_o), 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        for (int q = 0; q < 4; q++) begin
            query_slv_i = 2'(q); #0.1;
            chk("R1 slv_busy", int'(slv_busy_o), 0);
        end
        cmd_valid_i = 1; cmd_segs_i = 3'd3; #0.2;
        chk("R1 stall", int'(stall_o), 0);
        cmd_valid_i = 0;

        // Seeded sweep over mode, seed ID, seed slave and seed segments.
        for (int m = 0; m < 2; m++) begin
            for (int pid = 0; pid < 4; pid++) begin
                for (int si = 0; si < 2; si++) begin
                    for (int ss = 1; ss <= 2; ss++) begin
                        int sv;
                        sv = si * 3;
                        reorder_en = m[0];
                        commit(pid, sv, sv ^ 1, ss);
                        chk("R9 nonempty", int'(empty_o), 0);
                        for (int q = 0; q < 4; q++) begin
                            query_slv_i = 2'(q); #0.1;
                            chk("R10 slv_busy", int'(slv_busy_o), int'(m_scnt[q] != 0));
                        end
                        for (int id = 0; id < 4; id++)
                          for (int slv = 0; slv < 4; slv++)
                            for (int qos = 0; qos < 4; qos++)
                              for (int s = 1; s <= 3; s++) begin
                                  bit h, r;
                                  string tag;
                                  cmd_id_i = 2'(id); cmd_slv_i = 2'(slv);
                                  cmd_qos_i = 2'(qos); cmd_segs_i = 3'(s);
                                  cmd_valid_i = 1; dn_ready_i = 0;
                                  #0.1;
                                  h = exp_haz(id, slv, qos, s);
                                  r = exp_room(s);
                                  tag = m ? "R5" : (ss > 1 ? "R4" : (s > 1 ? "R3" : "R2"));
                                  chk({tag, " stall"}, int'(stall_o), int'(h));
                                  chk("R6 dn_valid", int'(dn_valid_o), int'(!h && r));
                                  chk("R6 ready", int'(cmd_ready_o), 0);
                              end
                        cmd_valid_i = 0;
                        for (int k = 0; k < ss; k++) retire(pid, sv);
                        chk("R9 drained", int'(empty_o), 1);
                    end
                end
            end
        end

        // R8 / R12: capacity boundary in reorder mode.
        reorder_en = 1;
        for (int k = 0; k < 5; k++) commit(0, 0, 0, 1);
        chk("R8 not full", int'(full_o), 0);
        @(negedge clk);
        cmd_id_i = 2'd1; cmd_slv_i = 2'd1; cmd_qos_i = 2'd2; cmd_segs_i = 3'd2;
        cmd_valid_i = 1; dn_ready_i = 1;
        #1;
        chk("R12 no stall on room", int'(stall_o), 0);
        chk("R8 overflow refused", int'(cmd_ready_o), 0);
        @(posedge clk); #1;
        cmd_valid_i = 0; dn_ready_i = 0;
        commit(0, 0, 0, 1);
        chk("R8 full", int'(full_o), 1);
        @(negedge clk);
        cmd_id_i = 2'd2; cmd_segs_i = 3'd1; cmd_valid_i = 1; dn_ready_i = 1;
        #1;
        chk("R8 full refuses", int'(cmd_ready_o), 0);
        @(posedge clk); #1;
        cmd_valid_i = 0; dn_ready_i = 0;
        chk("R8 still full", int'(full_o), 1);
        for (int k = 0; k < 5; k++) retire(0, 0);
        chk("R8 one left", int'(empty_o), 0);
        retire(0, 0);
        chk("R8 drained", int'(empty_o), 1);

        // R11: same-cycle accept and retire on one ID.
        reorder_en = 0;
        commit(1, 2, 0, 1);
        @(negedge clk);
        cmd_id_i = 2'd1; cmd_slv_i = 2'd2; cmd_qos_i = 2'd0; cmd_segs_i = 3'd1;
        cmd_valid_i = 1; dn_ready_i = 1;
        rsp_id_i = 2'd1; rsp_slv_i = 2'd2; rsp_valid_i = 1;
        #1;
        chk("R11 accept", int'(cmd_ready_o), 1);
        @(posedge clk); #1;
        cmd_valid_i = 0; dn_ready_i = 0; rsp_valid_i = 0;
        chk("R11 count kept", int'(empty_o), 0);
        query_slv_i = 2'd2; #0.1;
        chk("R11 slave kept", int'(slv_busy_o), 1);
        retire(1, 2);
        chk("R11 drained", int'(empty_o), 1);

        // R7: ignored responses and zero segment count.
        retire(2, 1);
        chk("R7 ignore on empty", int'(empty_o), 1);
        chk("R7 no full", int'(full_o), 0);
        commit(0, 1, 0, 1);
        retire(3, 1);
        chk("R7 ignore idle ID", int'(empty_o), 0);
        query_slv_i = 2'd1; #0.1;
        chk("R7 slave untouched", int'(slv_busy_o), 1);
        retire(0, 1);
        chk("R7 retired", int'(empty_o), 1);
        commit(2, 0, 0, 0);
        retire(2, 0);
        chk("R7 zero segs as one", int'(empty_o), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule